// File: doc/BRIEF.md
# Receive Frame Record Writer

This block sits between a receive byte stream and a byte-wide circular receive buffer. Each frame arrives one byte per cycle with a start marker on the first byte and an end marker on the last. The block turns it into a self-describing record that host software can read back as 32-bit words. The record starts with a constant marker word and a descriptor word holding the record's data length. The payload follows, zero-extended to the minimum frame size. After the payload comes a CRC-32 word, and then zero fill up to the next 4-byte boundary.

The block writes the record straight into the buffer memory through a byte write port. It owns the commit pointer, and the separate reader returns its read pointer. The descriptor word can only be filled in once the frame length is known, so the two header words are written last. The commit pointer then moves past the whole record in one step, and the reader never sees part of a record. A new frame is admitted only when reception is enabled and the free space covers the largest possible record. Until then the source is held off through a ready signal. Each committed record increments a pending-record counter and sets a sticky receive interrupt.

Top module: `rx_encap_writer`

## Requirements
- R1: A record is laid out as marker word (parameter MAGIC, default 0x0143414D), descriptor word, payload, pad bytes, CRC word, then zero bytes until its total length is a multiple of 4. Every word is stored little-endian, so its bit 7..0 byte sits at the lowest address. The record begins at the old commit pointer.
- R2: A payload shorter than MIN_PAYLOAD (60) bytes is extended with zero bytes to MIN_PAYLOAD bytes, and those zero bytes are covered by the CRC.
- R3: The descriptor word holds the padded payload length plus 4 in bits 15..0 and a one in bit 22, with all other bits zero.
- R4: The CRC word is the reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones, result inverted) over the padded payload. It is stored least significant byte first.
- R5: While no frame is in progress, src_ready is high exactly when rx_enable is high and the free space is at least the reserve. Free space is 2^ADDR_W minus (commit_ptr minus rd_ptr). The reserve is 8 + MAX_PAYLOAD + 4 rounded up to a multiple of 4, which is 1532 by default.
- R6: commit_ptr stays still while a record is being written. It then advances once, by exactly the record length, after the last byte of the record has been written.
- R7: In the cycle commit_ptr advances, pkt_count increases by one and rx_irq becomes 1.
- R8: A pkt_taken pulse lowers pkt_count by one. It has no effect when pkt_count is zero. A pulse in the commit cycle leaves pkt_count unchanged.
- R9: rx_irq stays set until an irq_clear pulse. If a commit and irq_clear fall in the same cycle, rx_irq ends up set.
- R10: Payload bytes beyond MAX_PAYLOAD are accepted and discarded. The record then holds only the first MAX_PAYLOAD bytes.
- R11: A byte offered without a start marker while no frame is in progress is consumed and discarded, with no memory write and no change to commit_ptr or pkt_count.
- R12: From the start marker to the end marker, src_ready stays high so that one byte moves per cycle, and lowering rx_enable in that time does not abort the frame.
- R13: After reset, commit_ptr and pkt_count are zero, rx_irq is low, and src_ready is low while rx_enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Reception enable, tested when a frame starts |
| src_valid | input | 1 | Source byte valid |
| src_sof | input | 1 | First byte of frame |
| src_eof | input | 1 | Last byte of frame |
| src_data | input | 8 | Frame byte |
| src_ready | output | 1 | Block accepts the offered byte |
| mem_we | output | 1 | Buffer byte write enable |
| mem_addr | output | ADDR_W | Buffer byte address |
| mem_wdata | output | 8 | Buffer byte write data |
| rd_ptr | input | ADDR_W+1 | Reader's position, wrap bit included |
| commit_ptr | output | ADDR_W+1 | End of the last complete record, wrap bit included |
| pkt_taken | input | 1 | Reader has consumed one record |
| pkt_count | output | CNT_W | Records committed and not yet consumed |
| irq_clear | input | 1 | Clears the receive interrupt |
| rx_irq | output | 1 | Sticky receive interrupt |

## Verification
A record commit can land in the same clock edge as the reader's consume pulse and as the interrupt clear. The bench provokes this by watching the write port for the last descriptor byte, at the old commit pointer plus 7. In that cycle it raises pkt_taken and irq_clear, so both arrive on the commit edge. It then expects pkt_count unchanged and rx_irq still set. A follow-up clear alone must drop the interrupt, and a consume at zero must leave the counter at zero.

// File: rtl/rx_encap_pkg.sv
package rx_encap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DATA  = 3'd1,
    ST_PAD   = 3'd2,
    ST_CRC   = 3'd3,
    ST_ALIGN = 3'd4,
    ST_HDR   = 3'd5
  } rxe_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam int unsigned HDR_BYTES     = 8;
  localparam int unsigned CRC_BYTES     = 4;
  localparam int unsigned OK_FLAG_BIT   = 22;

  // One byte of the reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

  function automatic int unsigned round_up4(input int unsigned v);
    return ((v + 3) / 4) * 4;
  endfunction

endpackage

// File: rtl/rx_encap_crc.sv
module rx_encap_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        step_en,
  input  logic [7:0]  step_byte,
  output logic [31:0] crc_q
);
  import rx_encap_pkg::*;

  logic [31:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (restart) begin
      crc_d = '1;
    end else if (step_en) begin
      crc_d = crc32_step(crc_q, step_byte);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '1;
    end else if (restart || step_en) begin
      crc_q <= crc_d;
    end
  end

endmodule

// File: rtl/rx_encap_space.sv
module rx_encap_space #(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned RESERVE = 1532
) (
  input  logic            rx_enable,
  input  logic [ADDR_W:0] commit_ptr,
  input  logic [ADDR_W:0] rd_ptr,
  output logic            admit
);
  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W:0] RES_V   = (PTR_W + 1)'(RESERVE);
  localparam logic [PTR_W:0] DEPTH_V = (PTR_W + 1)'(DEPTH);

  logic [PTR_W-1:0] used;
  logic [PTR_W:0]   free_bytes;

  always_comb begin
    used       = commit_ptr - rd_ptr;
    free_bytes = DEPTH_V - {1'b0, used};
    admit      = rx_enable && (free_bytes >= RES_V);
  end

endmodule

// File: rtl/rx_encap_status.sv
module rx_encap_status #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             pkt_taken,
  input  logic             irq_clear,
  output logic [CNT_W-1:0] pkt_count,
  output logic             rx_irq
);
  logic [CNT_W-1:0] cnt_d;
  logic             irq_d;
  logic             dec;
  logic             cnt_en;

  always_comb begin
    dec    = pkt_taken && ((pkt_count != '0) || commit);
    cnt_en = commit ^ dec;
    cnt_d  = pkt_count;
    if (commit && !dec) begin
      cnt_d = pkt_count + CNT_W'(1);
    end else if (dec && !commit) begin
      cnt_d = pkt_count - CNT_W'(1);
    end
    // A new record outranks a clear arriving in the same cycle.
    irq_d = commit || (rx_irq && !irq_clear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_count <= '0;
    end else if (cnt_en) begin
      pkt_count <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_irq <= 1'b0;
    end else begin
      rx_irq <= irq_d;
    end
  end

endmodule

// File: rtl/rx_encap_seq.sv
module rx_encap_seq #(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned MAX_PAYLOAD = 1518,
  parameter int unsigned MIN_PAYLOAD = 60,
  parameter logic [31:0] MAGIC       = 32'h0143414D,
  parameter int unsigned LEN_W       = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              admit,
  input  logic              src_valid,
  input  logic              src_sof,
  input  logic              src_eof,
  input  logic [7:0]        src_data,
  output logic              src_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              crc_restart,
  output logic              crc_en,
  output logic [7:0]        crc_byte,
  input  logic [31:0]       crc_val,
  output logic [ADDR_W:0]   commit_ptr,
  output logic              commit
);
  import rx_encap_pkg::*;

  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_PAYLOAD);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_PAYLOAD);

  rxe_state_e       state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d;   // padded payload length so far
  logic [LEN_W-1:0] off_q, off_d;   // bytes written past the header
  logic [2:0]       bcnt_q, bcnt_d; // byte index in CRC or header
  logic [PTR_W-1:0] ptr_d;
  logic             accept;
  logic             use_off;
  logic [31:0]      crc_fin;
  logic [31:0]      info_word;
  logic [31:0]      hdr_word;

  always_comb begin
    crc_fin   = ~crc_val;
    info_word = '0;
    info_word[15:0]        = 16'(len_q) + 16'd4;
    info_word[OK_FLAG_BIT] = 1'b1;
    hdr_word  = bcnt_q[2] ? info_word : MAGIC;
  end

  always_comb begin
    state_d   = state_q;
    len_d     = len_q;
    off_d     = off_q;
    bcnt_d    = bcnt_q;
    ptr_d     = commit_ptr;
    mem_we    = 1'b0;
    mem_wdata = 8'd0;
    use_off   = 1'b1;
    crc_en    = 1'b0;
    crc_byte  = 8'd0;
    commit    = 1'b0;
    src_ready = (state_q == ST_IDLE) ? admit : (state_q == ST_DATA);
    accept    = src_valid && src_ready;

    unique case (state_q)
      ST_IDLE: begin
        if (accept && src_sof) begin
          mem_we    = 1'b1;
          mem_wdata = src_data;
          crc_en    = 1'b1;
          crc_byte  = src_data;
          len_d     = len_q + LEN_W'(1);
          off_d     = off_q + LEN_W'(1);
          state_d   = src_eof ? ST_PAD : ST_DATA;
        end
      end
      ST_DATA: begin
        if (accept) begin
          if (len_q < MAX_L) begin
            mem_we    = 1'b1;
            mem_wdata = src_data;
            crc_en    = 1'b1;
            crc_byte  = src_data;
            len_d     = len_q + LEN_W'(1);
            off_d     = off_q + LEN_W'(1);
          end
          if (src_eof) begin
            state_d = ST_PAD;
          end
        end
      end
      ST_PAD: begin
        if (len_q < MIN_L) begin
          mem_we = 1'b1;
          crc_en = 1'b1;
          len_d  = len_q + LEN_W'(1);
          off_d  = off_q + LEN_W'(1);
        end else begin
          state_d = ST_CRC;
          bcnt_d  = 3'd0;
        end
      end
      ST_CRC: begin
        mem_we    = 1'b1;
        mem_wdata = crc_fin[8*bcnt_q[1:0] +: 8];
        off_d     = off_q + LEN_W'(1);
        bcnt_d    = bcnt_q + 3'd1;
        if (bcnt_q == 3'd3) begin
          state_d = ST_ALIGN;
        end
      end
      ST_ALIGN: begin
        if (off_q[1:0] != 2'b00) begin
          mem_we = 1'b1;
          off_d  = off_q + LEN_W'(1);
        end else begin
          state_d = ST_HDR;
          bcnt_d  = 3'd0;
        end
      end
      ST_HDR: begin
        mem_we    = 1'b1;
        use_off   = 1'b0;
        mem_wdata = hdr_word[8*bcnt_q[1:0] +: 8];
        bcnt_d    = bcnt_q + 3'd1;
        if (bcnt_q == 3'd7) begin
          commit  = 1'b1;
          ptr_d   = commit_ptr + PTR_W'(HDR_BYTES) + PTR_W'(off_q);
          len_d   = '0;
          off_d   = '0;
          bcnt_d  = 3'd0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    crc_restart = commit;
    mem_addr    = commit_ptr[ADDR_W-1:0] +
                  (use_off ? (ADDR_W'(HDR_BYTES) + ADDR_W'(off_q)) : ADDR_W'(bcnt_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      off_q   <= '0;
      bcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      off_q   <= off_d;
      bcnt_q  <= bcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_ptr <= '0;
    end else if (commit) begin
      commit_ptr <= ptr_d;
    end
  end

endmodule

// File: rtl/rx_encap_writer.sv
module rx_encap_writer #(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned MAX_PAYLOAD = 1518,
  parameter int unsigned MIN_PAYLOAD = 60,
  parameter logic [31:0] MAGIC       = 32'h0143414D,
  parameter int unsigned CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              src_valid,
  input  logic              src_sof,
  input  logic              src_eof,
  input  logic [7:0]        src_data,
  output logic              src_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [ADDR_W:0]   rd_ptr,
  output logic [ADDR_W:0]   commit_ptr,
  input  logic              pkt_taken,
  output logic [CNT_W-1:0]  pkt_count,
  input  logic              irq_clear,
  output logic              rx_irq
);
  import rx_encap_pkg::*;

  localparam int unsigned RESERVE = round_up4(HDR_BYTES + MAX_PAYLOAD + CRC_BYTES);
  localparam int unsigned LEN_W   = $clog2(RESERVE + 1);

  logic [1:0]  rst_sync_q;
  logic        core_rst_n;
  logic        admit;
  logic        crc_restart;
  logic        crc_en;
  logic [7:0]  crc_byte;
  logic [31:0] crc_val;
  logic        commit;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  rx_encap_space #(
    .ADDR_W  (ADDR_W),
    .RESERVE (RESERVE)
  ) u_space (
    .rx_enable  (rx_enable),
    .commit_ptr (commit_ptr),
    .rd_ptr     (rd_ptr),
    .admit      (admit)
  );

  rx_encap_crc u_crc (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .restart   (crc_restart),
    .step_en   (crc_en),
    .step_byte (crc_byte),
    .crc_q     (crc_val)
  );

  rx_encap_seq #(
    .ADDR_W      (ADDR_W),
    .MAX_PAYLOAD (MAX_PAYLOAD),
    .MIN_PAYLOAD (MIN_PAYLOAD),
    .MAGIC       (MAGIC),
    .LEN_W       (LEN_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .admit       (admit),
    .src_valid   (src_valid),
    .src_sof     (src_sof),
    .src_eof     (src_eof),
    .src_data    (src_data),
    .src_ready   (src_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .crc_restart (crc_restart),
    .crc_en      (crc_en),
    .crc_byte    (crc_byte),
    .crc_val     (crc_val),
    .commit_ptr  (commit_ptr),
    .commit      (commit)
  );

  rx_encap_status #(
    .CNT_W (CNT_W)
  ) u_status (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .commit    (commit),
    .pkt_taken (pkt_taken),
    .irq_clear (irq_clear),
    .pkt_count (pkt_count),
    .rx_irq    (rx_irq)
  );

endmodule

// File: rtl/rx_encap_writer_chk.sv
module rx_encap_writer_chk #(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned MIN_PAYLOAD = 60,
  parameter int unsigned CNT_W       = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ADDR_W:0]  rd_ptr,
  input logic [ADDR_W:0]  commit_ptr,
  input logic [CNT_W-1:0] pkt_count,
  input logic             irq_clear,
  input logic             rx_irq
);
  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_V  = PTR_W'(1 << ADDR_W);
  localparam logic [PTR_W-1:0] MIN_REC  = PTR_W'(8 + MIN_PAYLOAD + 4);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    PTR_W'(commit_ptr - rd_ptr) <= DEPTH_V);  // R5

  AST_COMMIT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ptr != $past(commit_ptr)) |-> (PTR_W'(commit_ptr - $past(commit_ptr)) % 4 == 0));  // R1

  AST_COMMIT_MIN_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ptr != $past(commit_ptr)) |-> (PTR_W'(commit_ptr - $past(commit_ptr)) >= MIN_REC));  // R2

  AST_COMMIT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ptr != $past(commit_ptr)) |-> rx_irq);  // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(pkt_count - $past(pkt_count)) inside {CNT_W'(0), CNT_W'(1), {CNT_W{1'b1}}}));  // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_irq) && !$past(irq_clear)) |-> rx_irq);  // R9

endmodule

bind rx_encap_writer rx_encap_writer_chk #(
  .ADDR_W      (ADDR_W),
  .MIN_PAYLOAD (MIN_PAYLOAD),
  .CNT_W       (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_ptr     (rd_ptr),
  .commit_ptr (commit_ptr),
  .pkt_count  (pkt_count),
  .irq_clear  (irq_clear),
  .rx_irq     (rx_irq)
);

// File: tb/rx_encap_writer_test.sv
`timescale 1ns/1ps
module rx_encap_writer_test;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int MAXP  = 70;
  localparam int MINP  = 60;
  localparam int CW    = 4;
  localparam logic [31:0] MAGIC = 32'h0143414D;
  localparam int RESV  = ((8 + MAXP + 4 + 3) / 4) * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_enable = 1'b0;
  logic          src_valid = 1'b0;
  logic          src_sof = 1'b0;
  logic          src_eof = 1'b0;
  logic [7:0]    src_data = 8'd0;
  logic          src_ready;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [AW:0]   rd_ptr = '0;
  logic [AW:0]   commit_ptr;
  logic          pkt_taken = 1'b0;
  logic [CW-1:0] pkt_count;
  logic          irq_clear = 1'b0;
  logic          rx_irq;

  int checks = 0;
  int errors = 0;
  int writes = 0;
  logic [7:0] mem [DEPTH];

  always #5 clk = ~clk;

  rx_encap_writer #(
    .ADDR_W(AW), .MAX_PAYLOAD(MAXP), .MIN_PAYLOAD(MINP), .MAGIC(MAGIC), .CNT_W(CW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .src_valid(src_valid),
    .src_sof(src_sof), .src_eof(src_eof), .src_data(src_data), .src_ready(src_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_ptr(rd_ptr),
    .commit_ptr(commit_ptr), .pkt_taken(pkt_taken), .pkt_count(pkt_count),
    .irq_clear(irq_clear), .rx_irq(rx_irq)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      writes <= writes + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input int seed, input int i);
    return 8'((seed * 7 + i * 13 + 1) & 255);
  endfunction

  function automatic logic [7:0] rbyte(input int off);
    return mem[(int'(rd_ptr) + off) % DEPTH];
  endfunction

  function automatic logic [31:0] rword(input int off);
    return {rbyte(off + 3), rbyte(off + 2), rbyte(off + 1), rbyte(off)};
  endfunction

  function automatic int rec_len(input int sent);
    int n, p;
    n = (sent > MAXP) ? MAXP : sent;
    p = (n < MINP) ? MINP : n;
    return ((8 + p + 4 + 3) / 4) * 4;
  endfunction

  function automatic int used_bytes();
    return (int'(commit_ptr) - int'(rd_ptr) + 2 * DEPTH) % (2 * DEPTH);
  endfunction

  task automatic send_frame(input int len, input int seed, input int drop_en_at);
    @(negedge clk);
    while (!src_ready) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      src_valid = 1'b1;
      src_sof   = (i == 0);
      src_eof   = (i == len - 1);
      src_data  = fb(seed, i);
      if (i == drop_en_at) rx_enable = 1'b0;
      if (i > 0) check(src_ready == 1'b1, "R12", src_ready, 1);
      @(negedge clk);
    end
    src_valid = 1'b0;
    src_sof   = 1'b0;
    src_eof   = 1'b0;
  endtask

  task automatic wait_commit(input string req);
    logic [AW:0] prev;
    bit seen;
    prev = commit_ptr;
    seen = 1'b0;
    for (int t = 0; t < 400 && !seen; t++) begin
      @(negedge clk);
      if (commit_ptr != prev) seen = 1'b1;
    end
    check(seen, req, 0, 1);
  endtask

  task automatic check_record(input int sent, input int seed);
    int n, p, rec, bad;
    logic [31:0] crc, exp_info;
    logic [7:0] b;
    n = (sent > MAXP) ? MAXP : sent;
    p = (n < MINP) ? MINP : n;
    rec = rec_len(sent);
    check(rword(0) == MAGIC, "R1", rword(0), MAGIC);
    exp_info = (32'd1 << 22) | 32'(p + 4);
    check(rword(4) == exp_info, "R3", rword(4), exp_info);
    bad = 0;
    crc = 32'hFFFFFFFF;
    for (int i = 0; i < p; i++) begin
      b = (i < n) ? fb(seed, i) : 8'd0;
      if (rbyte(8 + i) != b) bad++;
      crc = crc ^ {24'd0, b};
      for (int k = 0; k < 8; k++) crc = crc[0] ? ((crc >> 1) ^ 32'hEDB88320) : (crc >> 1);
    end
    crc = ~crc;
    check(bad == 0, (n > MAXP - 1 && sent > MAXP) ? "R10" : (n < MINP ? "R2" : "R1"), bad, 0);
    check(rword(8 + p) == crc, "R4", rword(8 + p), crc);
    bad = 0;
    for (int i = 8 + p + 4; i < rec; i++) if (rbyte(i) != 8'd0) bad++;
    check(bad == 0, "R1", bad, 0);
  endtask

  task automatic consume(input int rec);
    @(negedge clk);
    pkt_taken = 1'b1;
    irq_clear = 1'b1;
    rd_ptr    = rd_ptr + (AW + 1)'(rec);
    @(negedge clk);
    pkt_taken = 1'b0;
    irq_clear = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW:0] c0, ca;
    int w0, rec_a, rec_b, used;
    bit hit;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R13 reset state
    check(commit_ptr == '0, "R13", commit_ptr, 0);
    check(pkt_count == '0, "R13", pkt_count, 0);
    check(rx_irq == 1'b0, "R13", rx_irq, 0);
    check(src_ready == 1'b0, "R13", src_ready, 0);
    check(writes == 0, "R13", writes, 0);

    rx_enable = 1'b1;
    @(negedge clk);
    check(src_ready == 1'b1, "R5", src_ready, 1);

    // R11 stray byte without start marker
    c0 = commit_ptr; w0 = writes;
    src_valid = 1'b1; src_data = 8'hA5;
    @(negedge clk);
    src_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(writes == w0, "R11", writes, w0);
    check(commit_ptr == c0, "R11", commit_ptr, c0);
    check(pkt_count == '0, "R11", pkt_count, 0);

    // Sweep every frame length through the short, normal and truncated ranges
    for (int len = 1; len <= MAXP + 2; len++) begin
      c0 = commit_ptr;
      send_frame(len, len, -1);
      check(commit_ptr == c0, "R6", commit_ptr, c0);
      wait_commit("R6");
      check(used_bytes() == rec_len(len), "R6", used_bytes(), rec_len(len));
      check(pkt_count == CW'(1), "R7", pkt_count, 1);
      check(rx_irq == 1'b1, "R7", rx_irq, 1);
      check_record(len, len);
      consume(rec_len(len));
      check(pkt_count == '0, "R8", pkt_count, 0);
      check(rx_irq == 1'b0, "R9", rx_irq, 0);
    end

    // R12: rx_enable lowered mid-frame does not abort the frame
    send_frame(64, 200, 10);
    wait_commit("R12");
    check_record(64, 200);
    check(src_ready == 1'b0, "R5", src_ready, 0);
    consume(rec_len(64));
    rx_enable = 1'b1;

    // R5: fill the buffer until the reserve no longer fits
    ca = rd_ptr;
    for (int k = 0; k < 3; k++) begin
      send_frame(60, 40 + k, -1);
      wait_commit("R5");
      used = used_bytes();
      @(negedge clk);
      check(src_ready == ((DEPTH - used) >= RESV), "R5", src_ready, ((DEPTH - used) >= RESV));
    end
    check(src_ready == 1'b0, "R5", src_ready, 0);
    check(pkt_count == CW'(3), "R7", pkt_count, 3);
    for (int k = 0; k < 3; k++) begin
      check_record(60, 40 + k);
      consume(rec_len(60));
    end
    @(negedge clk);
    check(src_ready == 1'b1, "R5", src_ready, 1);
    check(commit_ptr == rd_ptr, "R6", commit_ptr, rd_ptr);

    // R8/R9: consume and clear land on the commit edge
    send_frame(61, 90, -1);
    wait_commit("R7");
    rec_a = rec_len(61);
    send_frame(62, 91, -1);
    rec_b = rec_len(62);
    hit = 1'b0;
    for (int t = 0; t < 400 && !hit; t++) begin
      @(negedge clk);
      if (mem_we && (mem_addr == AW'(commit_ptr[AW-1:0] + AW'(7)))) hit = 1'b1;
    end
    check(hit, "R8", hit, 1);
    pkt_taken = 1'b1;
    irq_clear = 1'b1;
    @(negedge clk);
    pkt_taken = 1'b0;
    irq_clear = 1'b0;
    check(pkt_count == CW'(1), "R8", pkt_count, 1);
    check(rx_irq == 1'b1, "R9", rx_irq, 1);
    check(used_bytes() == rec_a + rec_b, "R6", used_bytes(), rec_a + rec_b);
    check_record(61, 90);
    rd_ptr = rd_ptr + (AW + 1)'(rec_a);
    check_record(62, 91);
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    check(rx_irq == 1'b0, "R9", rx_irq, 0);
    consume(rec_b);
    check(pkt_count == '0, "R8", pkt_count, 0);
    pkt_taken = 1'b1;
    @(negedge clk);
    pkt_taken = 1'b0;
    check(pkt_count == '0, "R8", pkt_count, 0);

    // R5: disabled reception holds off the source
    rx_enable = 1'b0;
    @(negedge clk);
    check(src_ready == 1'b0, "R5", src_ready, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule